// File: doc/BRIEF.md
# Board Interrupt Router with Private Interrupt Placement

This block sits between a baseboard and a multicore interrupt controller and does nothing but steer level-sensitive request lines. Each of the 64 board request lines is broadcast to the same input index of four secondary board-level interrupt controllers. The lower half of the board lines is also passed through a sparse, fixed lookup onto the 32 CPU-side request lines. The four secondary controllers return their combined requests, and these drive CPU lines 10 through 13.

The block also builds the full input vector of the multicore controller. The external portion of that vector carries the CPU-side lines. For each core, a 32-entry private window follows. The private timer request of the core lands at entry 29 of its window and its watchdog request at entry 30. The window of core i starts at `(NUM_IRQ - 32) + 32*i`. `NUM_IRQ` counts both the 32 internal and the external entries. It defaults to 64 and may range from 32 up to 256.

Board lines may be asynchronous, so they pass through a resettable synchroniser whose depth `SYNC_STAGES` may be 0. All other paths are combinational. The block never latches a level: every destination follows its source.

Top module: `board_irq_router`

## Requirements
- R1: Board line n (0..63) drives bit `64*k + n` of `sec_ctrl_in` for each secondary controller k (0..3), at the same level.
- R2: For board lines below 32, the following pairs (board line → CPU line) set the CPU line: 19→0, 4→1, 5→2, 29→3, 12→4, 13→5, 10→6, 20→7, 21→8, 28→9, 17→14, 18→15.
- R3: Board lines 32..63, and board lines below 32 that do not appear in the R2 list, never drive any CPU line.
- R4: Secondary controller output k drives CPU line 10+k. Each CPU line is the OR of all its sources, and CPU lines 16..31 stay low.
- R5: For core i, `ctrl_vec` bit `(NUM_IRQ-32) + 32*i + 29` equals the core's timer request and bit `(NUM_IRQ-32) + 32*i + 30` equals its watchdog request.
- R6: `ctrl_vec` bit j, for j below both 32 and `NUM_IRQ-32`, equals CPU line j. Every other bit of the external portion, and every other private-window bit, is low.
- R7: With `SYNC_STAGES` = S, a change on `board_irq` reaches every destination after exactly S rising clock edges. Secondary, timer and watchdog inputs reach their destinations in the same cycle.
- R8: While `rst` is high, the synchroniser is cleared, and board lines reach no destination until after reset is released.
- R9: Routing is level-preserving with no latching: once a source falls, every destination it drove falls once its path latency has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchroniser |
| rst | input | 1 | Synchronous active-high reset |
| board_irq | input | 64 | Board request lines, level-sensitive, possibly asynchronous |
| sec_ctrl_out | input | 4 | Request outputs returned by the four secondary controllers |
| core_timer_irq | input | NUM_CORES | Private timer request per core |
| core_wdog_irq | input | NUM_CORES | Private watchdog request per core |
| sec_ctrl_in | output | 256 | Broadcast board lines, 64 per secondary controller |
| cpu_irq | output | 32 | CPU-side request lines |
| ctrl_vec | output | (NUM_IRQ-32)+32*NUM_CORES | Multicore controller input vector |

## Verification
The bench walks a single active line across all 64 board inputs. This exposes an off-by-one or swapped remap entry as a wrong CPU bit, and a line forwarded that should be dropped as a spurious one. It samples one edge before the synchroniser's expected latency and again at that latency, so a stage added or missing shows up as an early or late change. It also drives a secondary controller together with a remapped board line, so a design that selects one source instead of OR-ing them loses a request. A second instance with a larger interrupt count checks the private window base: a base computed without the external count puts timer and watchdog requests into the external region.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int BOARD_LINES  = 64;
    localparam int SEC_CTRLS    = 4;
    localparam int CPU_LINES    = 32;
    localparam int REMAP_SPAN   = 32;
    localparam int SEC_CPU_BASE = 10;
    localparam int PRIV_SPAN    = 32;
    localparam int TIMER_SLOT   = 29;
    localparam int WDOG_SLOT    = 30;

    typedef struct packed {
        logic       hit;
        logic [4:0] line;
    } remap_t;

    // Sparse board-to-CPU lookup; lines without an entry are dropped.
    function automatic remap_t remap_lookup(input int unsigned brd);
        remap_t r;
        r = '{hit: 1'b0, line: 5'd0};
        case (brd)
            19: r = '{hit: 1'b1, line: 5'd0};
            4:  r = '{hit: 1'b1, line: 5'd1};
            5:  r = '{hit: 1'b1, line: 5'd2};
            29: r = '{hit: 1'b1, line: 5'd3};
            12: r = '{hit: 1'b1, line: 5'd4};
            13: r = '{hit: 1'b1, line: 5'd5};
            10: r = '{hit: 1'b1, line: 5'd6};
            20: r = '{hit: 1'b1, line: 5'd7};
            21: r = '{hit: 1'b1, line: 5'd8};
            28: r = '{hit: 1'b1, line: 5'd9};
            17: r = '{hit: 1'b1, line: 5'd14};
            18: r = '{hit: 1'b1, line: 5'd15};
            default: r = '{hit: 1'b0, line: 5'd0};
        endcase
        return r;
    endfunction

    function automatic int unsigned priv_base(input int unsigned num_irq,
                                              input int unsigned core);
        return (num_irq - 32) + PRIV_SPAN * core;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe <= '0;
                end else begin
                    pipe[0] <= d_i;
                    for (int s = 1; s < STAGES; s++) begin
                        pipe[s] <= pipe[s-1];
                    end
                end
            end
            assign q_o = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_board_fanout.sv
module irq_board_fanout
    import irq_route_pkg::*;
(
    input  logic [BOARD_LINES-1:0]                lvl_i,
    input  logic [SEC_CTRLS-1:0]                  sec_done_i,
    output logic [SEC_CTRLS-1:0][BOARD_LINES-1:0] sec_in_o,
    output logic [CPU_LINES-1:0]                  cpu_o
);
    always_comb begin
        for (int k = 0; k < SEC_CTRLS; k++) begin
            sec_in_o[k] = lvl_i;
        end
    end

    always_comb begin
        remap_t r;
        cpu_o = '0;
        for (int b = 0; b < REMAP_SPAN; b++) begin
            r = remap_lookup(b);
            if (r.hit) begin
                cpu_o[r.line] = cpu_o[r.line] | lvl_i[b];
            end
        end
        for (int k = 0; k < SEC_CTRLS; k++) begin
            cpu_o[SEC_CPU_BASE + k] = cpu_o[SEC_CPU_BASE + k] | sec_done_i[k];
        end
    end
endmodule

// File: rtl/irq_ppi_place.sv
module irq_ppi_place
    import irq_route_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_IRQ   = 64,
    localparam int EXT_IRQ  = NUM_IRQ - 32,
    localparam int VEC_W    = EXT_IRQ + PRIV_SPAN * NUM_CORES,
    localparam int COPY_N   = (EXT_IRQ < CPU_LINES) ? EXT_IRQ : CPU_LINES
) (
    input  logic [CPU_LINES-1:0] cpu_i,
    input  logic [NUM_CORES-1:0] timer_i,
    input  logic [NUM_CORES-1:0] wdog_i,
    output logic [VEC_W-1:0]     vec_o
);
    always_comb begin
        vec_o = '0;
        for (int j = 0; j < COPY_N; j++) begin
            vec_o[j] = cpu_i[j];
        end
        for (int i = 0; i < NUM_CORES; i++) begin
            vec_o[priv_base(NUM_IRQ, i) + TIMER_SLOT] = timer_i[i];
            vec_o[priv_base(NUM_IRQ, i) + WDOG_SLOT]  = wdog_i[i];
        end
    end
endmodule

// File: rtl/board_irq_router.sv
module board_irq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int NUM_IRQ     = 64,
    parameter int SYNC_STAGES = 2,
    localparam int EXT_IRQ    = NUM_IRQ - 32,
    localparam int VEC_W      = EXT_IRQ + PRIV_SPAN * NUM_CORES,
    localparam int SEC_W      = SEC_CTRLS * BOARD_LINES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BOARD_LINES-1:0] board_irq,
    input  logic [SEC_CTRLS-1:0]   sec_ctrl_out,
    input  logic [NUM_CORES-1:0]   core_timer_irq,
    input  logic [NUM_CORES-1:0]   core_wdog_irq,
    output logic [SEC_W-1:0]       sec_ctrl_in,
    output logic [CPU_LINES-1:0]   cpu_irq,
    output logic [VEC_W-1:0]       ctrl_vec
);
    logic [BOARD_LINES-1:0]                board_s;
    logic [SEC_CTRLS-1:0][BOARD_LINES-1:0] sec_arr;

    irq_sync #(.WIDTH(BOARD_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (board_irq),
        .q_o (board_s)
    );

    irq_board_fanout u_fan (
        .lvl_i      (board_s),
        .sec_done_i (sec_ctrl_out),
        .sec_in_o   (sec_arr),
        .cpu_o      (cpu_irq)
    );

    assign sec_ctrl_in = sec_arr;

    irq_ppi_place #(.NUM_CORES(NUM_CORES), .NUM_IRQ(NUM_IRQ)) u_place (
        .cpu_i   (cpu_irq),
        .timer_i (core_timer_irq),
        .wdog_i  (core_wdog_irq),
        .vec_o   (ctrl_vec)
    );

    // ---------------- assertions ----------------
    genvar gk, gb, gi;
    generate
        for (gk = 1; gk < SEC_CTRLS; gk++) begin : g_a_bcast
            p_bcast_equal_r1: assert property (@(posedge clk) disable iff (rst)
                sec_ctrl_in[gk*BOARD_LINES +: BOARD_LINES] == sec_ctrl_in[0 +: BOARD_LINES]);
        end
        for (gb = 0; gb < REMAP_SPAN; gb++) begin : g_a_remap
            localparam remap_t ENT = remap_lookup(gb);
            if (ENT.hit) begin : g_hit
                p_remap_agree_r2: assert property (@(posedge clk) disable iff (rst)
                    cpu_irq[ENT.line] == sec_ctrl_in[gb]);
            end
        end
        if (EXT_IRQ > SEC_CPU_BASE + SEC_CTRLS - 1) begin : g_a_sec
            for (gk = 0; gk < SEC_CTRLS; gk++) begin : g_k
                p_sec_route_r4: assert property (@(posedge clk) disable iff (rst)
                    ctrl_vec[SEC_CPU_BASE + gk] == sec_ctrl_out[gk]);
            end
        end
        for (gi = 0; gi < NUM_CORES; gi++) begin : g_a_ppi
            p_timer_slot_r5: assert property (@(posedge clk) disable iff (rst)
                ctrl_vec[priv_base(NUM_IRQ, gi) + TIMER_SLOT] == core_timer_irq[gi]);
            p_wdog_slot_r5: assert property (@(posedge clk) disable iff (rst)
                ctrl_vec[priv_base(NUM_IRQ, gi) + WDOG_SLOT] == core_wdog_irq[gi]);
        end
        if (SYNC_STAGES > 0) begin : g_a_rst
            p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (sec_ctrl_in == '0));
        end
    endgenerate

    p_upper_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(cpu_irq[CPU_LINES-1:16]) == 0);

    p_priv_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(ctrl_vec[VEC_W-1:EXT_IRQ]) ==
        $countones(core_timer_irq) + $countones(core_wdog_irq));

endmodule

// File: tb/board_irq_router_test.sv
`timescale 1ns/1ps
module board_irq_router_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [63:0]  b   = '0;
    logic [3:0]   sd  = '0;
    logic [3:0]   tm  = '0;
    logic [3:0]   wd  = '0;
    logic [255:0] sec_in;
    logic [31:0]  cpu;
    logic [159:0] vec;
    logic [255:0] sec2;
    logic [31:0]  cpu2;
    logic [127:0] vec2;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] cur_b = '0;

    always #2.5 clk = ~clk;

    board_irq_router uut (
        .clk(clk), .rst(rst), .board_irq(b), .sec_ctrl_out(sd),
        .core_timer_irq(tm), .core_wdog_irq(wd),
        .sec_ctrl_in(sec_in), .cpu_irq(cpu), .ctrl_vec(vec)
    );

    board_irq_router #(.NUM_CORES(2), .NUM_IRQ(96), .SYNC_STAGES(2)) uut_wide (
        .clk(clk), .rst(rst), .board_irq(b), .sec_ctrl_out(sd),
        .core_timer_irq(tm[1:0]), .core_wdog_irq(wd[1:0]),
        .sec_ctrl_in(sec2), .cpu_irq(cpu2), .ctrl_vec(vec2)
    );

    function automatic logic [31:0] exp_cpu(input logic [63:0] bv, input logic [3:0] s);
        logic [31:0] c;
        c = '0;
        c[0]  = bv[19]; c[1]  = bv[4];  c[2]  = bv[5];  c[3]  = bv[29];
        c[4]  = bv[12]; c[5]  = bv[13]; c[6]  = bv[10]; c[7]  = bv[20];
        c[8]  = bv[21]; c[9]  = bv[28]; c[14] = bv[17]; c[15] = bv[18];
        c[13:10] = s;
        return c;
    endfunction

    function automatic logic [255:0] exp_vec(input logic [31:0] c, input logic [3:0] t,
                                             input logic [3:0] w, input int ext, input int cores);
        logic [255:0] v;
        v = '0;
        for (int j = 0; j < ext && j < 32; j++) v[j] = c[j];
        for (int i = 0; i < cores; i++) begin
            v[ext + 32*i + 29] = t[i];
            v[ext + 32*i + 30] = w[i];
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " sec"},  sec_in, {4{cur_b}});
        chk({req, " cpu"},  {224'd0, cpu}, {224'd0, exp_cpu(cur_b, sd)});
        chk({req, " vec"},  {96'd0, vec}, exp_vec(exp_cpu(cur_b, sd), tm, wd, 32, 4));
        chk({req, " vec2"}, {128'd0, vec2}, exp_vec(exp_cpu(cur_b, sd), tm, wd, 64, 2));
    endtask

    // Drive at a falling edge; R7: unchanged after one rising edge, updated after two.
    task automatic apply_board(input logic [63:0] v, input string req);
        @(negedge clk) b = v;
        @(posedge clk);
        @(negedge clk);
        chk({req, " R7 early"}, sec_in, {4{cur_b}});
        @(posedge clk);
        @(negedge clk);
        cur_b = v;
        chk_all(req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        b = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 sec held in reset", sec_in, '0);
        chk("R8 cpu held in reset", {224'd0, cpu}, '0);
        b = '0;
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_b = '0;
        chk_all("R8 after reset");
    endtask

    task automatic t_walk();
        for (int n = 0; n < 64; n++) begin
            apply_board(64'd1 << n, "R1 R2 R3 walk");
        end
    endtask

    task automatic t_patterns();
        apply_board('1, "R1 R2 all ones");
        apply_board(64'hA5C3_0F96_3C5A_F00F, "R1 R2 mix");
        apply_board(64'hFFFF_FFFF_0000_0000, "R3 upper half only");
        apply_board(64'h0000_0000_CFC0_1F0F & ~64'h3060_3430, "R3 unmapped low lines");
        apply_board('0, "R9 deassert all");
    endtask

    task automatic t_sec_lines();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) sd = 4'b1 << k;
            #1 chk_all("R4 sec line alone");
        end
        apply_board(64'h3000_0000, "R4 OR with board");
        @(negedge clk) sd = 4'hF;
        #1 chk_all("R4 OR both sources");
        @(negedge clk) sd = 4'h0;
        #1 chk_all("R9 sec deassert");
        apply_board('0, "R9 board deassert");
    endtask

    task automatic t_ppi();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) tm = 4'b1 << i; wd = '0;
            #1 chk_all("R5 timer slot");
            @(negedge clk) tm = '0; wd = 4'b1 << i;
            #1 chk_all("R5 watchdog slot");
        end
        @(negedge clk) tm = 4'b1010; wd = 4'b0110;
        #1 chk_all("R6 private mix");
        apply_board(64'hFFFF_FFFF_FFFF_FFFF, "R6 external carries cpu");
        @(negedge clk) tm = '0; wd = '0;
        #1 chk_all("R9 private deassert");
        apply_board('0, "R9 clear");
    endtask

    task automatic t_mid_reset();
        apply_board(64'h0000_0000_3030_0010, "R8 preload");
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 mid reset clears", sec_in, '0);
        b = '0;
        rst = 1'b0;
        cur_b = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all("R8 after mid reset");
    endtask

    initial begin
        t_reset();
        t_walk();
        t_patterns();
        t_sec_lines();
        t_ppi();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule